// File: doc/BRIEF.md
# Display Row Bank Selector

This block sequences the rows of a four-row display memory onto the backplane phases of a multiplexed LCD frame. Each time the frame timing logic raises a phase tick, the block reports which memory row should be copied into the display output register. It also reports the backplane phase that row belongs to. A one-clock load strobe marks the cycle in which both indices are valid.

The number of phases in a frame follows the drive mode: one phase for static drive and two, three or four phases for the multiplexed modes. In static and two-phase drive, a bank setting moves the sequence onto the upper pair of rows. A controller can therefore prepare one image in rows 0/1 and another in rows 2/3 and switch between them. Mode and bank are sampled only on the tick that opens a frame, so a frame never mixes two settings.

The block is a two-state sequencer, a row mapper, and an output register. The sequencer has two states. `SQ_FRAME_START` means the next tick opens a frame and latches the settings. `SQ_MID_FRAME` means the next tick continues the current frame. There are four transitions:
- START to START on a tick when the frame has one phase.
- START to MID on a tick when the frame has more than one phase.
- MID to MID on a tick before the last phase.
- MID to START on the tick of the last phase.

Top module: `rbs_bank_sel`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, `load_stb` is 0, `row_idx` is 0 and `bp_phase` is 0.
- R2: `load_stb` is 1 in exactly the cycle after each clock edge that samples `phase_tick` high, and 0 in every other cycle.
- R3: With `drv_mode` = 3 (four phases), successive strobes give `bp_phase` 0,1,2,3 repeating, and `row_idx` equals `bp_phase`.
- R4: With `drv_mode` = 2 (three phases) and `bank_hi` = 0, successive strobes give `bp_phase` 0,1,2 repeating, and `row_idx` equals `bp_phase`.
- R5: With `drv_mode` = 1 (two phases) and `bank_hi` = 0, successive strobes give rows 0,1 repeating, at phases 0,1.
- R6: With `drv_mode` = 1 and `bank_hi` = 1, successive strobes give rows 2,3 repeating, at phases 0,1.
- R7: With `drv_mode` = 0 (static), every strobe has `bp_phase` 0. `row_idx` is 0 when `bank_hi` = 0 and 2 when `bank_hi` = 1.
- R8: With `drv_mode` = 2 or 3, the value of `bank_hi` has no effect on `row_idx` or `bp_phase`.
- R9: `drv_mode` and `bank_hi` are sampled only on a tick that gives `bp_phase` 0. A change made mid-frame first appears at the next phase-0 strobe.
- R10: Between strobes, `row_idx` and `bp_phase` hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_tick | input | 1 | One-cycle pulse that advances to the next backplane phase |
| drv_mode | input | 2 | Drive mode: 0 static, 1 two-phase, 2 three-phase, 3 four-phase |
| bank_hi | input | 1 | Selects the upper row pair in static and two-phase drive |
| row_idx | output | 2 | Display memory row to transfer |
| bp_phase | output | 2 | Backplane phase the row belongs to |
| load_stb | output | 1 | One-clock strobe marking valid `row_idx`/`bp_phase` |

## Verification
A wrong phase counter or a stuck sequencer state shows as a wrong `bp_phase` on the very next strobe. A wrong latched mode or bank shows as a row outside the expected sequence, at the latest on the strobe that closes the frame. Both are therefore visible within four ticks of the fault. The behavioural model in the bench tracks frame boundaries independently and compares every output on every clock. Mid-frame setting changes are driven deliberately, so that premature sampling of mode or bank surfaces at the first strobe after the change.

// File: rtl/rbs_pkg.sv
package rbs_pkg;

    typedef enum logic [1:0] {
        DRV_STATIC = 2'd0,
        DRV_MUX2   = 2'd1,
        DRV_MUX3   = 2'd2,
        DRV_MUX4   = 2'd3
    } drv_mode_e;

    typedef enum logic {
        SQ_FRAME_START = 1'b0,
        SQ_MID_FRAME   = 1'b1
    } seq_state_e;

    // phases per frame for a drive mode
    function automatic logic [2:0] phases_in_frame(drv_mode_e m);
        logic [2:0] n;
        unique case (m)
            DRV_STATIC: n = 3'd1;
            DRV_MUX2:   n = 3'd2;
            DRV_MUX3:   n = 3'd3;
            DRV_MUX4:   n = 3'd4;
            default:    n = 3'd1;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/rbs_seq.sv
module rbs_seq
    import rbs_pkg::*;
#(
    parameter int PH_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  drv_mode_e       mode_in,
    input  logic            bank_in,
    output drv_mode_e       eff_mode,
    output logic            eff_bank,
    output logic [PH_W-1:0] cur_phase
);

    localparam int CW = PH_W + 1;

    seq_state_e      state_q, state_d;
    logic [PH_W-1:0] ph_q, ph_d;
    drv_mode_e       mode_q;
    logic            bank_q;
    logic            last_ph;

    // Settings come straight from the inputs on a frame-opening tick
    always_comb begin
        eff_mode  = (state_q == SQ_FRAME_START) ? mode_in : mode_q;
        eff_bank  = (state_q == SQ_FRAME_START) ? bank_in : bank_q;
        cur_phase = ph_q;
        last_ph   = ({1'b0, ph_q} == CW'(phases_in_frame(eff_mode) - 3'd1));
    end

    always_comb begin
        state_d = state_q;
        ph_d    = ph_q;
        unique case (state_q)
            SQ_FRAME_START: begin
                if (tick) begin
                    if (last_ph) begin
                        state_d = SQ_FRAME_START;
                        ph_d    = '0;
                    end else begin
                        state_d = SQ_MID_FRAME;
                        ph_d    = ph_q + 1'b1;
                    end
                end
            end
            SQ_MID_FRAME: begin
                if (tick) begin
                    if (last_ph) begin
                        state_d = SQ_FRAME_START;
                        ph_d    = '0;
                    end else begin
                        state_d = SQ_MID_FRAME;
                        ph_d    = ph_q + 1'b1;
                    end
                end
            end
            default: begin
                state_d = SQ_FRAME_START;
                ph_d    = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_FRAME_START;
            ph_q    <= '0;
            mode_q  <= DRV_STATIC;
            bank_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            ph_q    <= ph_d;
            if (tick && state_q == SQ_FRAME_START) begin
                mode_q <= mode_in;
                bank_q <= bank_in;
            end
        end
    end

endmodule

// File: rtl/rbs_map.sv
module rbs_map
    import rbs_pkg::*;
#(
    parameter int ROW_W = 2
) (
    input  drv_mode_e        mode,
    input  logic             bank,
    input  logic [ROW_W-1:0] phase,
    output logic [ROW_W-1:0] row
);

    localparam logic [ROW_W-1:0] UPPER_OFS = ROW_W'(2);

    always_comb begin
        unique case (mode)
            DRV_STATIC: row = bank ? UPPER_OFS : '0;
            DRV_MUX2:   row = bank ? (phase + UPPER_OFS) : phase;
            DRV_MUX3:   row = phase;
            DRV_MUX4:   row = phase;
            default:    row = phase;
        endcase
    end

endmodule

// File: rtl/rbs_bank_sel.sv
module rbs_bank_sel
    import rbs_pkg::*;
#(
    parameter int ROW_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             phase_tick,
    input  logic [1:0]       drv_mode,
    input  logic             bank_hi,
    output logic [ROW_W-1:0] row_idx,
    output logic [ROW_W-1:0] bp_phase,
    output logic             load_stb
);

    drv_mode_e        eff_mode;
    logic             eff_bank;
    logic [ROW_W-1:0] cur_phase;
    logic [ROW_W-1:0] mapped_row;

    rbs_seq #(.PH_W(ROW_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (phase_tick),
        .mode_in   (drv_mode_e'(drv_mode)),
        .bank_in   (bank_hi),
        .eff_mode  (eff_mode),
        .eff_bank  (eff_bank),
        .cur_phase (cur_phase)
    );

    rbs_map #(.ROW_W(ROW_W)) u_map (
        .mode  (eff_mode),
        .bank  (eff_bank),
        .phase (cur_phase),
        .row   (mapped_row)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_idx  <= '0;
            bp_phase <= '0;
            load_stb <= 1'b0;
        end else begin
            load_stb <= phase_tick;
            if (phase_tick) begin
                row_idx  <= mapped_row;
                bp_phase <= cur_phase;
            end
        end
    end

endmodule

// File: rtl/rbs_bank_sel_chk.sv
module rbs_bank_sel_chk #(
    parameter int ROW_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             phase_tick,
    input logic [ROW_W-1:0] row_idx,
    input logic [ROW_W-1:0] bp_phase,
    input logic             load_stb
);

    logic [ROW_W-1:0] last_bp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        last_bp <= '0;
        else if (load_stb) last_bp <= bp_phase;
    end

    a_r2_strobe_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        phase_tick |=> load_stb);

    a_r2_no_spurious_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_tick |=> !load_stb);

    a_r10_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_tick |=> ($stable(row_idx) && $stable(bp_phase)));

    // R5/R6/R7: a row is either its phase or its phase in the upper pair
    a_r6_row_in_pair: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |-> (row_idx == bp_phase || row_idx == bp_phase + ROW_W'(2)));

    a_r9_phase_steps: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |-> (bp_phase == '0 || bp_phase == last_bp + 1'b1));

endmodule

bind rbs_bank_sel rbs_bank_sel_chk #(.ROW_W(ROW_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase_tick (phase_tick),
    .row_idx    (row_idx),
    .bp_phase   (bp_phase),
    .load_stb   (load_stb)
);

// File: tb/sim_rbs_bank_sel.sv
module sim_rbs_bank_sel;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       phase_tick = 1'b0;
    logic [1:0] drv_mode = 2'd0;
    logic       bank_hi = 1'b0;
    logic [1:0] row_idx, bp_phase;
    logic       load_stb;

    int    checks = 0;
    int    errors = 0;
    bit    comparing = 0;
    bit    reported = 0;
    string cur_req = "R3";

    // reference model state
    int m_ph = 0, m_mode = 0, m_bank = 0;
    int exp_row = 0, exp_bp = 0, exp_stb = 0;

    rbs_bank_sel u0 (
        .clk(clk), .rst_n(rst_n), .phase_tick(phase_tick),
        .drv_mode(drv_mode), .bank_hi(bank_hi),
        .row_idx(row_idx), .bp_phase(bp_phase), .load_stb(load_stb)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        int len;
        if (!rst_n) begin
            m_ph = 0; exp_row = 0; exp_bp = 0; exp_stb = 0;
        end else if (phase_tick) begin
            if (m_ph == 0) begin
                m_mode = int'(drv_mode);
                m_bank = int'(bank_hi);
            end
            len = m_mode + 1;
            exp_bp = m_ph;
            if (m_mode == 0)      exp_row = m_bank ? 2 : 0;
            else if (m_mode == 1) exp_row = m_bank ? m_ph + 2 : m_ph;
            else                  exp_row = m_ph;
            exp_stb = 1;
            m_ph = (m_ph + 1) % len;
        end else begin
            exp_stb = 0;
        end
    end

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (comparing) begin
            check("R2", "load_stb", int'(load_stb), exp_stb);
            if (exp_stb != 0) begin
                check(cur_req, "row_idx", int'(row_idx), exp_row);
                check(cur_req, "bp_phase", int'(bp_phase), exp_bp);
            end else begin
                check("R10", "row_idx held", int'(row_idx), exp_row);
                check("R10", "bp_phase held", int'(bp_phase), exp_bp);
            end
        end
    end

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic ticks(int n, int gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) phase_tick = 1'b1;
            @(negedge clk) phase_tick = 1'b0;
            for (int g = 0; g < gap; g++) @(negedge clk);
        end
    endtask

    task automatic setup(int mode, int bank, string req);
        @(negedge clk);
        drv_mode = 2'(mode);
        bank_hi  = 1'(bank);
        cur_req  = req;
    endtask

    initial begin
        #150000;
        checks++; errors++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        // R1: outputs during reset
        repeat (3) @(negedge clk);
        check("R1", "load_stb in reset", int'(load_stb), 0);
        check("R1", "row_idx in reset", int'(row_idx), 0);
        check("R1", "bp_phase in reset", int'(bp_phase), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "row_idx after reset", int'(row_idx), 0);
        comparing = 1;

        // four-phase frames start from reset phase 0
        setup(3, 0, "R3"); ticks(8, 0);
        ticks(4, 3);                        // R10 long gaps
        setup(3, 1, "R8"); ticks(8, 1);
        setup(2, 1, "R8"); ticks(1, 0);     // frame boundary, mode 3 frame over
        ticks(6, 0);
        setup(2, 0, "R4"); ticks(9, 2);
        setup(1, 0, "R5"); ticks(6, 0);
        setup(1, 1, "R6"); ticks(6, 1);
        setup(0, 0, "R7"); ticks(4, 0);
        setup(0, 1, "R7"); ticks(4, 2);

        // R9: settings changed mid-frame
        setup(3, 0, "R9"); ticks(4, 0);
        ticks(2, 0);
        setup(1, 1, "R9"); ticks(6, 0);     // takes effect at next phase 0
        ticks(1, 0);
        setup(2, 0, "R9"); ticks(6, 1);
        setup(0, 1, "R9"); ticks(1, 0);
        setup(3, 0, "R9"); ticks(5, 0);

        // back-to-back settings churn every tick
        for (int k = 0; k < 24; k++) begin
            setup(k % 4, (k / 4) % 2, "R9");
            ticks(1, k % 3);
        end

        repeat (4) @(negedge clk);
        report();
    end

endmodule